// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block holds the architectural control state that a 32-bit core needs in order to enter a handler: the status word, the vector base, the three save registers (saved PC, saved status, saved stack pointer), the event-code, interrupt-code and trap registers, and two physical copies of the low eight general registers. A request arrives as a one-cycle pulse with a class and a code, together with the current PC, the current stack register value and a flag telling whether the faulting instruction sits in a branch delay slot. One clock later the block presents the handler address with a load strobe, has saved the interrupted context, and has rewritten the status word for privileged, blocked, alternate-bank operation.

The active copy of R0..R7 follows the register-bank bit of the status word. Any change of that bit, whether by a software status write or by handler entry, exchanges which copy is visible. The core reads and writes the visible copy through an index port and can also read the hidden copy. A reset-class request returns the core to the boot address with the vector base cleared. An ordinary exception requested while the vector base is still zero cannot be dispatched, so the block raises a sticky halt instead.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset: pc_out = 0xA0000000, pc_next = 0xA0000002, vbr_out = 0, sr_out = 0x700000F0, expevt_out = 0x000, halt = 0, pc_load = 0.
- R2: A general exception (ev_kind 0) with vbr_out nonzero gives, one cycle later, spc_out = cur_pc, ssr_out = the prior sr_out, sgr_out = r15, expevt_out = ev_code, pc_out = vbr_out + 0x100, and pc_load high for exactly that cycle.
- R3: On handler entry sr_out becomes the prior status with bit 30 (privileged), bit 29 (bank select) and bit 28 (event block) set and every other bit kept.
- R4: A TLB exception (ev_kind 1) vectors to vbr + 0x400. An interrupt (ev_kind 3) vectors to vbr + 0x600, writes ev_code to intevt_out, leaves expevt_out unchanged, saves cur_pc without slot adjustment and does not pulse slot_clr.
- R5: An exception (ev_kind 0, 1, 2 or 5) with in_slot high saves cur_pc - 2 in spc_out and pulses slot_clr for one cycle.
- R6: A trap (ev_kind 2) writes trap_imm shifted left by 2, zero-extended, to tra_out, writes 0x160 to expevt_out and vectors to vbr + 0x100.
- R7: A slot-sensitive fault (ev_kind 5) writes ev_slot_code to expevt_out when in_slot is high and ev_code otherwise.
- R8: reg_rd_data returns the copy selected by sr_out bit 29 and bank_rd_data the other copy; reg_wr_en writes the selected copy; a status write that flips bit 29 exchanges the two views, and one that keeps it leaves them as they were.
- R9: A reset-class request (ev_kind 4) sets pc_out = 0xA0000000, vbr_out = 0, expevt_out = ev_code, sets sr bits 30, 29, 28 and 7:4, clears sr bit 15, and leaves the save registers unchanged.
- R10: An exception (ev_kind 0, 1, 2, 5) with vbr_out = 0 sets halt and does not vector or save; halt stays high and all further requests are ignored until rst_n.
- R11: A request in the same cycle as sr_wr_en takes priority: the status write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event request strobe |
| ev_kind | input | 3 | 0 general, 1 TLB, 2 trap, 3 interrupt, 4 reset-class, 5 slot-sensitive; 6 and 7 ignored |
| ev_code | input | 12 | Event code |
| ev_slot_code | input | 12 | Alternate code for a slot-sensitive fault in a delay slot |
| trap_imm | input | 8 | Trap immediate |
| cur_pc | input | 32 | PC of the interrupted instruction |
| r15 | input | 32 | Current stack register value |
| in_slot | input | 1 | Faulting instruction is in a delay slot |
| sr_wr_en | input | 1 | Software status write strobe |
| sr_wr_data | input | 32 | Status write value |
| vbr_wr_en | input | 1 | Vector base write strobe |
| vbr_wr_data | input | 32 | Vector base write value |
| reg_wr_en | input | 1 | Write strobe for the visible R0..R7 |
| reg_wr_idx | input | 3 | Write index |
| reg_wr_data | input | 32 | Write value |
| reg_rd_idx | input | 3 | Read index for both copies |
| reg_rd_data | output | 32 | Visible copy at reg_rd_idx |
| bank_rd_data | output | 32 | Hidden copy at reg_rd_idx |
| pc_load | output | 1 | One-cycle strobe: load pc_out |
| pc_out | output | 32 | Handler or boot address |
| pc_next | output | 32 | pc_out + 2 |
| slot_clr | output | 1 | One-cycle strobe: clear the delay-slot flag |
| halt | output | 1 | Sticky undispatchable-exception stop |
| bank_sel | output | 1 | Current bank select bit |
| sr_out | output | 32 | Status word |
| vbr_out | output | 32 | Vector base |
| spc_out | output | 32 | Saved PC |
| ssr_out | output | 32 | Saved status |
| sgr_out | output | 32 | Saved stack register |
| expevt_out | output | 12 | Exception event code |
| intevt_out | output | 12 | Interrupt event code |
| tra_out | output | 32 | Trap register |

## Verification
The hardest state to reach from the ports is the bank exchange, because the two copies look identical unless they hold different data. The stimulus writes a marker into one copy, flips the bank bit by a status write, writes a second marker into the other copy, and then flips back with both a toggling and a non-toggling status write, reading both views each time. The halt case needs the vector base back at zero after normal operation, which the stimulus reaches through a reset-class request before raising an ordinary exception.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int          CODE_W    = 12,
  parameter int          NREG      = 8,
  parameter logic [31:0] BOOT_PC   = 32'hA000_0000,
  parameter logic [31:0] BOOT_SR   = 32'h7000_00F0,
  parameter logic [11:0] TRAP_CODE = 12'h160,
  parameter logic [11:0] OFF_GEN   = 12'h100,
  parameter logic [11:0] OFF_TLB   = 12'h400,
  parameter logic [11:0] OFF_IRQ   = 12'h600,
  localparam int         IDXW      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [CODE_W-1:0] ev_slot_code,
  input  logic [7:0]        trap_imm,
  input  logic [31:0]       cur_pc,
  input  logic [31:0]       r15,
  input  logic              in_slot,
  input  logic              sr_wr_en,
  input  logic [31:0]       sr_wr_data,
  input  logic              vbr_wr_en,
  input  logic [31:0]       vbr_wr_data,
  input  logic              reg_wr_en,
  input  logic [IDXW-1:0]   reg_wr_idx,
  input  logic [31:0]       reg_wr_data,
  input  logic [IDXW-1:0]   reg_rd_idx,
  output logic [31:0]       reg_rd_data,
  output logic [31:0]       bank_rd_data,
  output logic              pc_load,
  output logic [31:0]       pc_out,
  output logic [31:0]       pc_next,
  output logic              slot_clr,
  output logic              halt,
  output logic              bank_sel,
  output logic [31:0]       sr_out,
  output logic [31:0]       vbr_out,
  output logic [31:0]       spc_out,
  output logic [31:0]       ssr_out,
  output logic [31:0]       sgr_out,
  output logic [CODE_W-1:0] expevt_out,
  output logic [CODE_W-1:0] intevt_out,
  output logic [31:0]       tra_out
);
  localparam logic [2:0] K_GEN = 3'd0, K_TLB = 3'd1, K_TRAP = 3'd2,
                         K_IRQ = 3'd3, K_RST = 3'd4, K_SLOT = 3'd5;
  localparam int B_MD = 30, B_RB = 29, B_BL = 28, B_FD = 15;
  localparam logic [31:0] ENTRY_SET = (32'd1 << B_MD) | (32'd1 << B_RB) | (32'd1 << B_BL);
  localparam logic [31:0] IMASK_SET = 32'h0000_00F0;

  logic [31:0] sr_q, vbr_q, spc_q, ssr_q, sgr_q, pc_q, tra_q;
  logic [CODE_W-1:0] expevt_q, intevt_q;
  logic halt_q, load_q, clr_q;
  logic [31:0] bank0 [NREG];
  logic [31:0] bank1 [NREG];

  wire ev_act  = ev_valid && !halt_q && (ev_kind <= K_SLOT);
  wire is_irq  = ev_kind == K_IRQ;
  wire is_rst  = ev_kind == K_RST;
  wire is_exc  = !is_irq && !is_rst;
  wire no_vbr  = vbr_q == 32'd0;
  wire fault   = ev_act && is_exc && no_vbr;
  wire enter   = ev_act && (is_irq || (is_exc && !no_vbr));
  wire rst_cls = ev_act && is_rst;

  logic [CODE_W-1:0] exc_code;
  logic [11:0]       vec_off;

  always_comb begin
    exc_code = ev_code;
    if (ev_kind == K_TRAP) exc_code = CODE_W'(TRAP_CODE);
    else if (ev_kind == K_SLOT && in_slot) exc_code = ev_slot_code;
  end

  always_comb begin
    case (ev_kind)
      K_TLB:   vec_off = OFF_TLB;
      K_IRQ:   vec_off = OFF_IRQ;
      default: vec_off = OFF_GEN;
    endcase
  end

  wire [31:0] sr_entry = sr_q | ENTRY_SET;
  wire [31:0] sr_boot  = (sr_q | ENTRY_SET | IMASK_SET) & ~(32'd1 << B_FD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= BOOT_SR;
      vbr_q    <= 32'd0;
      pc_q     <= BOOT_PC;
      spc_q    <= 32'd0;
      ssr_q    <= 32'd0;
      sgr_q    <= 32'd0;
      tra_q    <= 32'd0;
      expevt_q <= '0;
      intevt_q <= '0;
      halt_q   <= 1'b0;
      load_q   <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      load_q <= 1'b0;
      clr_q  <= 1'b0;
      if (vbr_wr_en) vbr_q <= vbr_wr_data;
      if (sr_wr_en && !ev_act) sr_q <= sr_wr_data;
      if (rst_cls) begin
        sr_q     <= sr_boot;
        vbr_q    <= 32'd0;
        pc_q     <= BOOT_PC;
        expevt_q <= ev_code;
        load_q   <= 1'b1;
      end else if (fault) begin
        halt_q <= 1'b1;
      end else if (enter) begin
        spc_q  <= (is_exc && in_slot) ? cur_pc - 32'd2 : cur_pc;
        ssr_q  <= sr_q;
        sgr_q  <= r15;
        sr_q   <= sr_entry;
        pc_q   <= vbr_q + 32'(vec_off);
        load_q <= 1'b1;
        clr_q  <= is_exc && in_slot;
        if (is_irq) intevt_q <= ev_code;
        else expevt_q <= exc_code;
        if (ev_kind == K_TRAP) tra_q <= 32'({trap_imm, 2'b00});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        bank0[i] <= 32'd0;
        bank1[i] <= 32'd0;
      end
    end else if (reg_wr_en) begin
      if (sr_q[B_RB]) bank1[reg_wr_idx] <= reg_wr_data;
      else            bank0[reg_wr_idx] <= reg_wr_data;
    end
  end

  assign reg_rd_data  = sr_q[B_RB] ? bank1[reg_rd_idx] : bank0[reg_rd_idx];
  assign bank_rd_data = sr_q[B_RB] ? bank0[reg_rd_idx] : bank1[reg_rd_idx];
  assign bank_sel     = sr_q[B_RB];
  assign pc_load      = load_q;
  assign pc_out       = pc_q;
  assign pc_next      = pc_q + 32'd2;
  assign slot_clr     = clr_q;
  assign halt         = halt_q;
  assign sr_out       = sr_q;
  assign vbr_out      = vbr_q;
  assign spc_out      = spc_q;
  assign ssr_out      = ssr_q;
  assign sgr_out      = sgr_q;
  assign expevt_out   = expevt_q;
  assign intevt_out   = intevt_q;
  assign tra_out      = tra_q;

  p_entry_sr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (sr_out[30:28] == 3'b111) && pc_load);

  p_irq_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && is_irq) |=> (pc_out == $past(vbr_out) + 32'h600) && (intevt_out == $past(ev_code)) && !slot_clr);

  p_slot_spc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && is_exc && in_slot) |=> (spc_out == $past(cur_pc) - 32'd2) && slot_clr);

  p_trap_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && ev_kind == K_TRAP) |=> (tra_out[9:2] == $past(trap_imm)) && (tra_out[1:0] == 2'b00));

  p_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cls |=> (pc_out == BOOT_PC) && (vbr_out == 32'd0) && (sr_out[7:4] == 4'hF) && !sr_out[15]);

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt && !pc_load && $stable(pc_out));

  p_sr_pri_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && sr_wr_en) |=> sr_out == ($past(sr_out) | ENTRY_SET));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [31:0] VBR = 32'h8C00_0000;

  localparam logic [2:0]  T_KIND [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd5};
  localparam logic [11:0] T_CODE [NV] = '{12'h0E0, 12'h040, 12'h000, 12'h320, 12'h180, 12'h180};
  localparam logic [11:0] T_SCOD [NV] = '{12'h000, 12'h000, 12'h000, 12'h000, 12'h1A0, 12'h1A0};
  localparam logic [7:0]  T_IMM  [NV] = '{8'h00, 8'h00, 8'h2A, 8'h00, 8'h00, 8'h00};
  localparam logic [31:0] T_PC   [NV] = '{32'h8C01_0000, 32'h8C01_0040, 32'h8C01_0080,
                                          32'h8C01_00C0, 32'h8C01_0100, 32'h8C01_0140};
  localparam logic        T_SLOT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] T_VEC  [NV] = '{32'h8C00_0100, 32'h8C00_0400, 32'h8C00_0100,
                                          32'h8C00_0600, 32'h8C00_0100, 32'h8C00_0100};
  localparam logic [11:0] T_EXP  [NV] = '{12'h0E0, 12'h040, 12'h160, 12'h320, 12'h1A0, 12'h180};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, in_slot = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [11:0] ev_code = '0, ev_slot_code = '0;
  logic [7:0] trap_imm = '0;
  logic [31:0] cur_pc = '0, r15 = '0;
  logic sr_wr_en = 1'b0, vbr_wr_en = 1'b0, reg_wr_en = 1'b0;
  logic [31:0] sr_wr_data = '0, vbr_wr_data = '0, reg_wr_data = '0;
  logic [2:0] reg_wr_idx = '0, reg_rd_idx = '0;
  logic [31:0] reg_rd_data, bank_rd_data, pc_out, pc_next, sr_out, vbr_out;
  logic [31:0] spc_out, ssr_out, sgr_out, tra_out;
  logic [11:0] expevt_out, intevt_out;
  logic pc_load, slot_clr, halt, bank_sel;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_code(ev_code),
    .ev_slot_code(ev_slot_code), .trap_imm(trap_imm), .cur_pc(cur_pc), .r15(r15),
    .in_slot(in_slot), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .vbr_wr_en(vbr_wr_en),
    .vbr_wr_data(vbr_wr_data), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .bank_rd_data(bank_rd_data), .pc_load(pc_load), .pc_out(pc_out), .pc_next(pc_next),
    .slot_clr(slot_clr), .halt(halt), .bank_sel(bank_sel), .sr_out(sr_out), .vbr_out(vbr_out),
    .spc_out(spc_out), .ssr_out(ssr_out), .sgr_out(sgr_out), .expevt_out(expevt_out),
    .intevt_out(intevt_out), .tra_out(tra_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [2:0] k, input logic [11:0] c, input logic [11:0] sc,
                      input logic [7:0] imm, input logic [31:0] pc, input logic [31:0] sp,
                      input logic slot);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_code = c; ev_slot_code = sc;
    trap_imm = imm; cur_pc = pc; r15 = sp; in_slot = slot;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic put_sr(input logic [31:0] v);
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_data = v;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  task automatic put_reg(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] srb, old_spc;
    logic [11:0] old_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_out, 32'hA000_0000);
    chk("R1 next", pc_next, 32'hA000_0002);
    chk("R1 vbr", vbr_out, 32'd0);
    chk("R1 sr", sr_out, 32'h7000_00F0);
    chk("R1 expevt", 32'(expevt_out), 32'd0);
    chk("R1 halt/load", {30'd0, halt, pc_load}, 32'd0);

    @(negedge clk);
    vbr_wr_en = 1'b1; vbr_wr_data = VBR;
    @(negedge clk);
    vbr_wr_en = 1'b0;

    for (int i = 0; i < NV; i++) begin
      srb = 32'h0000_00F0 | 32'(i);
      put_sr(srb);
      old_exp = expevt_out;
      fire(T_KIND[i], T_CODE[i], T_SCOD[i], T_IMM[i], T_PC[i], 32'h0C00_1000 + 32'(i), T_SLOT[i]);
      // R2 R4 R6 vector, save registers, load strobe
      chk("R2/R4 vector", pc_out, T_VEC[i]);
      chk("R2 load", {31'd0, pc_load}, 32'd1);
      chk("R2 ssr", ssr_out, srb);
      chk("R2 sgr", sgr_out, 32'h0C00_1000 + 32'(i));
      chk("R3 sr", sr_out, srb | 32'h7000_0000);
      if (T_KIND[i] == 3'd3) begin
        chk("R4 intevt", 32'(intevt_out), 32'(T_EXP[i]));
        chk("R4 expevt kept", 32'(expevt_out), 32'(old_exp));
        chk("R4 spc", spc_out, T_PC[i]);
        chk("R4 no slot clr", {31'd0, slot_clr}, 32'd0);
      end else begin
        chk("R2/R6/R7 expevt", 32'(expevt_out), 32'(T_EXP[i]));
        chk("R5 spc", spc_out, T_SLOT[i] ? T_PC[i] - 32'd2 : T_PC[i]);
        chk("R5 slot clr", {31'd0, slot_clr}, {31'd0, T_SLOT[i]});
      end
      if (T_KIND[i] == 3'd2) chk("R6 tra", tra_out, 32'h0000_00A8);
      @(negedge clk);
      chk("R2 load pulse", {31'd0, pc_load}, 32'd0);
    end

    // R8 bank exchange
    put_sr(32'h0000_0000);
    reg_rd_idx = 3'd3;
    put_reg(3'd3, 32'h1111_1111);
    chk("R8 visible", reg_rd_data, 32'h1111_1111);
    put_sr(32'h2000_0000);
    chk("R8 swap hidden", bank_rd_data, 32'h1111_1111);
    chk("R8 swap visible", reg_rd_data, 32'd0);
    put_reg(3'd3, 32'h2222_2222);
    put_sr(32'h0000_0001);
    chk("R8 back visible", reg_rd_data, 32'h1111_1111);
    chk("R8 back hidden", bank_rd_data, 32'h2222_2222);
    put_sr(32'h0000_0003);
    chk("R8 no toggle", reg_rd_data, 32'h1111_1111);
    // R8 entry toggles the bank
    fire(3'd0, 12'h0E0, 12'h000, 8'h00, 32'h8C02_0000, 32'h0, 1'b0);
    chk("R8 entry swap", reg_rd_data, 32'h2222_2222);

    // R11 status write loses to a request
    put_sr(32'h0000_0010);
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_data = 32'h0000_0055;
    ev_valid = 1'b1; ev_kind = 3'd3; ev_code = 12'h3C0; in_slot = 1'b0;
    @(negedge clk);
    sr_wr_en = 1'b0; ev_valid = 1'b0;
    chk("R11 sr", sr_out, 32'h7000_0010);

    // R9 reset-class request
    put_sr(32'h0000_80A3);
    old_spc = spc_out;
    fire(3'd4, 12'h020, 12'h000, 8'h00, 32'h8C03_0000, 32'h0, 1'b0);
    chk("R9 pc", pc_out, 32'hA000_0000);
    chk("R9 vbr", vbr_out, 32'd0);
    chk("R9 sr", sr_out, 32'h7000_00F3);
    chk("R9 expevt", 32'(expevt_out), 32'h020);
    chk("R9 spc kept", spc_out, old_spc);

    // R10 exception with zero vector base
    fire(3'd1, 12'h040, 12'h000, 8'h00, 32'h8C04_0000, 32'h0, 1'b0);
    chk("R10 halt", {31'd0, halt}, 32'd1);
    chk("R10 no load", {31'd0, pc_load}, 32'd0);
    chk("R10 pc held", pc_out, 32'hA000_0000);
    chk("R10 spc held", spc_out, old_spc);
    @(negedge clk);
    vbr_wr_en = 1'b1; vbr_wr_data = VBR;
    @(negedge clk);
    vbr_wr_en = 1'b0;
    fire(3'd3, 12'h300, 12'h000, 8'h00, 32'h8C05_0000, 32'h0, 1'b0);
    chk("R10 ignored", pc_out, 32'hA000_0000);
    chk("R10 intevt held", 32'(intevt_out), 32'h3C0);
    chk("R10 still halted", {31'd0, halt}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cleared", {31'd0, halt}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule